// File: doc/BRIEF.md
# Clock Fan-Out Output-Enable Serial Slave

This block is the control side of a ten-pair differential clock fan-out device. It listens on a two-wire I2C bus as a receive-only slave. It holds one enable bit for each of ten output pairs, and it drives each pair's tri-state control from that bit. The bus lines are oversampled by the system clock. Start and stop conditions are recovered from the sampled lines, and the slave pulls the data line low to acknowledge.

A write transfer has a fixed layout. It opens with the write address byte 0xD2, which is the 7-bit address 1101001 followed by a write bit of 0. Two header bytes follow: a command byte and a count byte. The slave acknowledges both header bytes but gives them no meaning. Data bytes then fill the two enable registers in a strict order, with no register index in the transfer. A host therefore cannot reach the second register without rewriting the first. The feedback clock pair is not controlled here and is never tri-stated.

Top module: `clkoe_serial_slave`

## Requirements
- R1: After reset, every bit of `pair_en` is 1 and every bit of `pair_hiz` is 0.
- R2: When the byte after a START is 0xD2, the slave drives `sda_pull_low` high during the ninth SCL pulse. This acknowledges the byte.
- R3: When the byte after a START is any other value, the slave does not acknowledge it. This includes 0xD3, which is a read request. Every later byte up to the next START is then ignored and not acknowledged, and the enables do not change.
- R4: The two bytes after the address are acknowledged. Their values have no effect on the enables.
- R5: The first data byte is the first enable register. Its bit 7-k sets `pair_en[k]` for k = 0 to 7, so bit 7 controls pair 0 and bit 0 controls pair 7.
- R6: The second data byte is the second enable register. Its bit 7 sets `pair_en[8]` and its bit 6 sets `pair_en[9]`. Bits 5 to 0 are ignored.
- R7: Data bytes after the second are acknowledged and discarded.
- R8: A STOP or a repeated START ends the transfer, and the next data byte goes to the first register again. A transfer that stops after one data byte leaves the second register unchanged.
- R9: `pair_hiz[k]` is the inverse of `pair_en[k]`. A 0 enable bit puts pair k into high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| pair_en | output | 10 | Enable per output pair, bit k is pair k |
| pair_hiz | output | 10 | High-impedance request per output pair |

## Verification
The assertions check the following on every cycle. The acknowledge is held until the next SCL fall and released there. A foreign or read address is never acknowledged. A STOP clears the acknowledge. Each register changes only on a write strobe, and then it takes the strobed byte. The bench scenarios are needed for the behaviour that spans a whole transfer: the bit-to-pair mapping across a sweep of data patterns, discarding of the header and excess bytes, the pointer reset on repeated START, and the silence after a rejected address.

// File: rtl/clkoe_pkg.sv
package clkoe_pkg;

    localparam int NUM_PAIRS   = 10;
    localparam int LOW_PAIRS   = 8;
    localparam int HDR_BYTES   = 2;
    localparam int DATA_BYTES  = 2;
    localparam int IDX_W       = 3;
    localparam int BIT_CNT_W   = 4;
    localparam logic [6:0] SLAVE_ADDR = 7'b1101001;
    localparam logic [7:0] ADDR_WR    = {SLAVE_ADDR, 1'b0};

    localparam logic [IDX_W-1:0]     FIRST_DATA = IDX_W'(1 + HDR_BYTES);
    localparam logic [IDX_W-1:0]     IDX_MAX    = IDX_W'(1 + HDR_BYTES + DATA_BYTES);
    localparam logic [BIT_CNT_W-1:0] BYTE_DONE  = BIT_CNT_W'(8);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } xfer_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic       valid;
        logic       sel;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic [NUM_PAIRS-1:0] map_enables(input logic [7:0] lo_reg,
                                                          input logic [1:0] hi_bits);
        logic [NUM_PAIRS-1:0] res;
        for (int k = 0; k < LOW_PAIRS; k++) begin
            res[k] = lo_reg[LOW_PAIRS-1-k];
        end
        res[LOW_PAIRS]   = hi_bits[1];
        res[LOW_PAIRS+1] = hi_bits[0];
        return res;
    endfunction

endpackage

// File: rtl/clkoe_bus_sampler.sv
module clkoe_bus_sampler
    import clkoe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_q;
    logic sda_q;
    logic scl_cur;
    logic sda_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_cur;
            sda_q    <= sda_cur;
        end
    end

    assign scl_cur = scl_sync[SYNC_STAGES-1];
    assign sda_cur = sda_sync[SYNC_STAGES-1];

    always_comb begin
        evt.start    = scl_cur & scl_q & sda_q & ~sda_cur;
        evt.stop     = scl_cur & scl_q & ~sda_q & sda_cur;
        evt.scl_rise = scl_cur & ~scl_q;
        evt.scl_fall = ~scl_cur & scl_q;
        evt.sda      = sda_cur;
    end

endmodule

// File: rtl/clkoe_byte_engine.sv
module clkoe_byte_engine
    import clkoe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     ack_drive,
    output reg_wr_t  wr
);
    xfer_state_t          state;
    logic [BIT_CNT_W-1:0] cnt;
    logic [IDX_W-1:0]     idx;
    logic [7:0]           shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            wr    <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (evt.start) begin
                state <= ST_RECV;
                cnt   <= '0;
                idx   <= '0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (evt.scl_rise && cnt < BYTE_DONE) begin
                            shreg <= {shreg[6:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == BYTE_DONE) begin
                            if (idx == '0 && shreg != ADDR_WR) begin
                                state <= ST_SKIP;
                            end else begin
                                state <= ST_ACK;
                                if (idx >= FIRST_DATA && idx < IDX_MAX) begin
                                    wr.valid <= 1'b1;
                                    wr.sel   <= (idx != FIRST_DATA);
                                    wr.data  <= shreg;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            state <= ST_RECV;
                            cnt   <= '0;
                            if (idx != IDX_MAX) idx <= idx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ack_drive = (state == ST_ACK);

    p_nack_foreign_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV && evt.scl_fall && cnt == BYTE_DONE && idx == '0 &&
         shreg != ADDR_WR && !evt.start && !evt.stop) |=> !ack_drive);

    p_ack_release_r2: assert property (@(posedge clk) disable iff (rst)
        (ack_drive && evt.scl_fall && !evt.start && !evt.stop) |=> !ack_drive);

    p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_drive && !evt.scl_fall && !evt.start && !evt.stop) |=> ack_drive);

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !ack_drive);

endmodule

// File: rtl/clkoe_enable_regs.sv
module clkoe_enable_regs
    import clkoe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    output logic [NUM_PAIRS-1:0] pair_en
);
    logic [7:0] en_lo;
    logic [1:0] en_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_lo <= '1;
            en_hi <= '1;
        end else if (wr.valid) begin
            if (!wr.sel) en_lo <= wr.data;
            else         en_hi <= wr.data[7:6];
        end
    end

    assign pair_en = map_enables(en_lo, en_hi);

    p_lo_load_r5: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && !wr.sel) |=> en_lo == $past(wr.data));

    p_hi_load_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.sel) |=> en_hi == $past(wr.data[7:6]) && $stable(en_lo));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr.valid |=> $stable(en_lo) && $stable(en_hi));

endmodule

// File: rtl/clkoe_serial_slave.sv
module clkoe_serial_slave
    import clkoe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_pull_low,
    output logic [NUM_PAIRS-1:0] pair_en,
    output logic [NUM_PAIRS-1:0] pair_hiz
);
    bus_evt_t evt;
    reg_wr_t  wr;

    clkoe_bus_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    clkoe_byte_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .ack_drive (sda_pull_low),
        .wr        (wr)
    );

    clkoe_enable_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .pair_en (pair_en)
    );

    assign pair_hiz = ~pair_en;

endmodule

// File: tb/test_clkoe_serial_slave.sv
module test_clkoe_serial_slave;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_tb = 1'b1;
    logic       sda_pull_low;
    logic [9:0] pair_en;
    logic [9:0] pair_hiz;
    logic       sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    assign sda_line = sda_tb & ~sda_pull_low;

    always #4 clk = ~clk;

    clkoe_serial_slave i_clkoe_serial_slave (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .pair_en      (pair_en),
        .pair_hiz     (pair_hiz)
    );

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_en(input logic [7:0] b0, input logic [7:0] b1);
        logic [9:0] e;
        for (int k = 0; k < 8; k++) e[k] = (b0 >> (7 - k)) & 8'd1;
        e[8] = (b1 >> 7) & 8'd1;
        e[9] = (b1 >> 6) & 8'd1;
        return e;
    endfunction

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; qwait();
        scl = 1'b1;    qwait();
        sda_tb = 1'b0; qwait();
        scl = 1'b0;    qwait();
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; qwait();
        scl = 1'b1;    qwait();
        sda_tb = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_tb = b[i]; qwait();
            scl = 1'b1;    qwait(); qwait();
            scl = 1'b0;    qwait();
        end
        sda_tb = 1'b1; qwait();
        scl = 1'b1;    qwait();
        acked = ~sda_line;
        qwait();
        scl = 1'b0;    qwait();
    endtask

    task automatic full_write(input logic [7:0] cmd, input logic [7:0] cnt,
                              input logic [7:0] d0, input logic [7:0] d1, input string tag);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk({tag, " R2 addr ack"}, {9'd0, a}, 10'd1);
        send_byte(cmd, a);   chk({tag, " R4 cmd ack"},  {9'd0, a}, 10'd1);
        send_byte(cnt, a);   chk({tag, " R4 cnt ack"},  {9'd0, a}, 10'd1);
        send_byte(d0, a);    chk({tag, " R5 d0 ack"},   {9'd0, a}, 10'd1);
        send_byte(d1, a);    chk({tag, " R6 d1 ack"},   {9'd0, a}, 10'd1);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [9:0] cur;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset enables", pair_en, 10'h3FF);
        chk("R1 reset hiz", pair_hiz, 10'h000);
        chk("R1 no ack drive", {9'd0, sda_pull_low}, 10'd0);

        // R5 R6 R9 sweep of data patterns with varied header bytes (R4)
        for (int i = 0; i < 64; i++) begin
            logic [7:0] d0;
            logic [7:0] d1;
            d0 = 8'((i * 37 + 5) & 255);
            d1 = ~d0 ^ 8'(i);
            full_write(8'(i * 11), 8'(255 - i), d0, d1, "sweep");
            chk("R5_R6 sweep enables", pair_en, exp_en(d0, d1));
            chk("R9 sweep hiz", pair_hiz, ~exp_en(d0, d1));
        end

        full_write(8'h00, 8'h02, 8'hFF, 8'hFF, "restore");
        chk("R1 restore", pair_en, 10'h3FF);

        // R6 reserved bits of byte 1 have no effect
        full_write(8'hA5, 8'h02, 8'hFF, 8'h3F, "rsv");
        chk("R6 reserved ones ignored", pair_en, 10'h0FF);
        full_write(8'hA5, 8'h02, 8'hFF, 8'hC0, "rsv2");
        chk("R6 reserved zeros ignored", pair_en, 10'h3FF);

        // R3 wrong address: no ack, subsequent bytes ignored
        cur = pair_en;
        bus_start();
        send_byte(8'hD4, a); chk("R3 foreign addr nack", {9'd0, a}, 10'd0);
        send_byte(8'h00, a); chk("R3 skip no ack", {9'd0, a}, 10'd0);
        send_byte(8'h00, a);
        send_byte(8'h00, a); chk("R3 skip data no ack", {9'd0, a}, 10'd0);
        send_byte(8'h00, a);
        bus_stop();
        chk("R3 foreign no effect", pair_en, cur);

        // R3 read request
        bus_start();
        send_byte(8'hD3, a); chk("R3 read nack", {9'd0, a}, 10'd0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_stop();
        chk("R3 read no effect", pair_en, cur);

        // R7 extra bytes acked and discarded
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h5A, a);
        send_byte(8'h80, a);
        send_byte(8'h00, a); chk("R7 extra byte ack", {9'd0, a}, 10'd1);
        send_byte(8'h00, a); chk("R7 extra byte2 ack", {9'd0, a}, 10'd1);
        bus_stop();
        chk("R7 extra discarded", pair_en, exp_en(8'h5A, 8'h80));

        // R8 partial transfer leaves byte 1 alone
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'h0F, a);
        bus_stop();
        chk("R8 partial write", pair_en, exp_en(8'h0F, 8'h80));

        // R8 repeated START resets pointer
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h02, a);
        send_byte(8'h33, a);
        bus_start();
        send_byte(8'hD2, a); chk("R8 restart addr ack", {9'd0, a}, 10'd1);
        send_byte(8'hC3, a);
        send_byte(8'h3C, a);
        send_byte(8'hE1, a);
        send_byte(8'h40, a);
        bus_stop();
        chk("R8 restart pointer", pair_en, exp_en(8'hE1, 8'h40));
        chk("R9 restart hiz", pair_hiz, ~exp_en(8'hE1, 8'h40));

        // R3 then R2: a fresh START after a rejected address works again
        bus_start();
        send_byte(8'h52, a);
        bus_start();
        send_byte(8'hD2, a); chk("R2 ack after rejected", {9'd0, a}, 10'd1);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h81, a);
        bus_stop();
        chk("R5 after rejected", pair_en, exp_en(8'h81, 8'h40));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule